// File: doc/BRIEF.md
# Low-Power Sleep Depth Controller

This block decides how deeply the processor powers down when it executes a sleep instruction. It looks at two standby control register values at the moment the sleep strobe arrives. From them it picks one of three sleep depths. Each depth drops a different set of run enables. The CPU enable is dropped in every depth. The DMA enable is dropped only in the intermediate depth. The timer, serial and power-management enables are dropped only in the deepest depth.

While the block sleeps, a pending interrupt request returns it to the running state on the next clock edge. All enables are registered, so they change only on a clock edge. A sleep strobe that arrives while the block is already asleep has no effect.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: After reset (rst_n low) the state is RUN (code 2'b00) and all five enables (cpu_run, dma_run, tmr_run, ser_run, pwr_run) are 1.
- R2: A sleep strobe in RUN with standby_ctl[7]=1 moves the state to STANDBY (code 2'b11) at the next clock edge, whatever the value of deep_ctl[7].
- R3: A sleep strobe in RUN with standby_ctl[7]=0 and deep_ctl[7]=1 moves the state to DEEP (code 2'b10) at the next clock edge.
- R4: A sleep strobe in RUN with both standby_ctl[7] and deep_ctl[7] at 0 moves the state to SLEEP (code 2'b01) at the next clock edge.
- R5: In STANDBY, cpu_run, tmr_run, ser_run and pwr_run are 0 and dma_run is 1.
- R6: In DEEP, cpu_run and dma_run are 0 and the timer, serial and power-management enables stay 1.
- R7: In SLEEP, only cpu_run is 0.
- R8: In any sleep state, irq_pend sampled high at a clock edge returns the state to RUN with all enables at 1 after that same edge.
- R9: A sleep strobe received in a sleep state is ignored: the state code and the enables do not change while irq_pend is low.
- R10: The low bits (6:0) of both control values have no effect on which depth is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe from the executed sleep instruction |
| standby_ctl | input | 8 | First standby control value; bit 7 selects standby |
| deep_ctl | input | 8 | Second standby control value; bit 7 selects deep sleep |
| irq_pend | input | 1 | An interrupt request is pending |
| state_o | output | 2 | Encoded state: 00 run, 01 sleep, 10 deep, 11 standby |
| cpu_run | output | 1 | CPU run enable |
| dma_run | output | 1 | DMA controller run enable |
| tmr_run | output | 1 | Timer run enable |
| ser_run | output | 1 | Serial port run enable |
| pwr_run | output | 1 | Power-management run enable |

## Verification
The hardest case to reach is a sleep strobe that arrives while the block is already in a sleep depth and the control bits now point at a different depth. From the ports this looks exactly like a legal request. To produce it, the bench first enters one depth and holds irq_pend low. It then changes the control bits and pulses the strobe again. It confirms that both the state code and every enable keep the values of the original depth. It also checks the case where the strobe and irq_pend arrive in the same cycle while asleep, and expects a wake.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;
  localparam int CTL_W   = 8;
  localparam int SEL_BIT = 7;
  localparam int N_EN    = 5;

  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_SLEEP   = 2'b01,
    ST_DEEP    = 2'b10,
    ST_STANDBY = 2'b11
  } lp_state_e;

  typedef struct packed {
    logic cpu;
    logic dma;
    logic tmr;
    logic ser;
    logic pwr;
  } lp_en_t;

  function automatic lp_state_e pick_depth(input logic stby_bit, input logic deep_bit);
    if (stby_bit)      return ST_STANDBY;
    else if (deep_bit) return ST_DEEP;
    else               return ST_SLEEP;
  endfunction

  function automatic lp_en_t enables_for(input lp_state_e s);
    lp_en_t e;
    e = '{cpu: 1'b1, dma: 1'b1, tmr: 1'b1, ser: 1'b1, pwr: 1'b1};
    case (s)
      ST_SLEEP:   e.cpu = 1'b0;
      ST_DEEP:    begin e.cpu = 1'b0; e.dma = 1'b0; end
      ST_STANDBY: begin e.cpu = 1'b0; e.tmr = 1'b0; e.ser = 1'b0; e.pwr = 1'b0; end
      default:    ;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/lp_depth_sel.sv
module lp_depth_sel
  import lp_sleep_pkg::*;
#(
  parameter int W   = CTL_W,
  parameter int BIT = SEL_BIT
)(
  input  logic [W-1:0] stby_val,
  input  logic [W-1:0] deep_val,
  output lp_state_e    target
);
  always_comb target = pick_depth(stby_val[BIT], deep_val[BIT]);
endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm
  import lp_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      irq_pend,
  input  lp_state_e target,
  output lp_state_e state,
  output logic      go_sleep,
  output logic      go_wake
);
  lp_state_e nxt;
  logic asleep;

  assign asleep   = (state != ST_RUN);
  assign go_sleep = !asleep && sleep_req;
  assign go_wake  = asleep && irq_pend;

  always_comb begin
    nxt = state;
    if (go_sleep)     nxt = target;
    else if (go_wake) nxt = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/lp_enable_reg.sv
module lp_enable_reg
  import lp_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lp_state_e next_state,
  output lp_en_t    en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '{cpu: 1'b1, dma: 1'b1, tmr: 1'b1, ser: 1'b1, pwr: 1'b1};
    else        en <= enables_for(next_state);
  end
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
  import lp_sleep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [CTL_W-1:0] standby_ctl,
  input  logic [CTL_W-1:0] deep_ctl,
  input  logic             irq_pend,
  output logic [1:0]       state_o,
  output logic             cpu_run,
  output logic             dma_run,
  output logic             tmr_run,
  output logic             ser_run,
  output logic             pwr_run
);
  lp_state_e target;
  lp_state_e state;
  lp_state_e next_state;
  lp_en_t    en;
  logic      go_sleep;
  logic      go_wake;

  lp_depth_sel #(.W(CTL_W), .BIT(SEL_BIT)) u_sel (
    .stby_val(standby_ctl), .deep_val(deep_ctl), .target(target));

  lp_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_pend(irq_pend),
    .target(target), .state(state), .go_sleep(go_sleep), .go_wake(go_wake));

  always_comb begin
    next_state = state;
    if (go_sleep)     next_state = target;
    else if (go_wake) next_state = ST_RUN;
  end

  lp_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .next_state(next_state), .en(en));

  assign state_o = state;
  assign cpu_run = en.cpu;
  assign dma_run = en.dma;
  assign tmr_run = en.tmr;
  assign ser_run = en.ser;
  assign pwr_run = en.pwr;
endmodule

// File: rtl/lp_sleep_chk.sv
module lp_sleep_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [7:0] standby_ctl,
  input logic [7:0] deep_ctl,
  input logic       irq_pend,
  input logic [1:0] state_o,
  input logic       cpu_run,
  input logic       dma_run,
  input logic       tmr_run,
  input logic       ser_run,
  input logic       pwr_run
);
  // R2
  standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sleep_req && standby_ctl[7]) |=> state_o == 2'b11);
  // R3
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sleep_req && !standby_ctl[7] && deep_ctl[7]) |=> state_o == 2'b10);
  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sleep_req && !standby_ctl[7] && !deep_ctl[7]) |=> state_o == 2'b01);
  // R5
  standby_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b11 |-> (!cpu_run && dma_run && !tmr_run && !ser_run && !pwr_run));
  // R6
  deep_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b10 |-> (!cpu_run && !dma_run && tmr_run && ser_run && pwr_run));
  // R7
  sleep_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b01 |-> (!cpu_run && dma_run && tmr_run && ser_run && pwr_run));
  // R8
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b00 && irq_pend) |=> (state_o == 2'b00 && cpu_run));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b00 && !irq_pend) |=> $stable(state_o));
  // R1
  run_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b00 |-> ($countones({cpu_run, dma_run, tmr_run, ser_run, pwr_run}) == 5));
endmodule

bind lp_sleep_ctrl lp_sleep_chk u_chk (.*);

// File: tb/test_lp_sleep_ctrl.sv
`timescale 1ns/1ps
module test_lp_sleep_ctrl;
  logic clk = 0;
  logic rst_n = 0;
  logic sleep_req = 0;
  logic [7:0] standby_ctl = 0;
  logic [7:0] deep_ctl = 0;
  logic irq_pend = 0;
  logic [1:0] state_o;
  logic cpu_run, dma_run, tmr_run, ser_run, pwr_run;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_sleep_ctrl i_lp_sleep_ctrl (.*);

  task automatic check(input string req, input logic [1:0] exp_st, input logic [4:0] exp_en);
    logic [4:0] act;
    act = {cpu_run, dma_run, tmr_run, ser_run, pwr_run};
    n_tests++;
    if (state_o !== exp_st || act !== exp_en) begin
      n_fail++;
      $display("FAIL %s: state=%b en=%b expected state=%b en=%b", req, state_o, act, exp_st, exp_en);
    end
  endtask

  // drive at negedge, sample at the following negedge after the posedge
  task automatic strobe(input logic [7:0] s, input logic [7:0] d);
    @(negedge clk); standby_ctl = s; deep_ctl = d; sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic wake();
    @(negedge clk); irq_pend = 1;
    @(negedge clk); irq_pend = 0;
  endtask

  task automatic t_reset();
    check("R1", 2'b00, 5'b11111);
  endtask

  task automatic t_standby();
    strobe(8'h80, 8'h80); check("R2", 2'b11, 5'b01000);
    check("R5", 2'b11, 5'b01000);
    wake(); check("R8", 2'b00, 5'b11111);
  endtask

  task automatic t_deep();
    strobe(8'h7F, 8'h80); check("R3", 2'b10, 5'b00111);
    check("R6", 2'b10, 5'b00111);
    wake(); check("R8", 2'b00, 5'b11111);
  endtask

  task automatic t_sleep();
    strobe(8'h7F, 8'h7F); check("R4", 2'b01, 5'b01111);
    check("R7", 2'b01, 5'b01111);
    check("R10", 2'b01, 5'b01111);
    wake(); check("R8", 2'b00, 5'b11111);
  endtask

  task automatic t_ignore();
    strobe(8'h00, 8'h00); check("R4", 2'b01, 5'b01111);
    strobe(8'h80, 8'h00); check("R9", 2'b01, 5'b01111);
    strobe(8'h00, 8'h80); check("R9", 2'b01, 5'b01111);
    repeat (3) @(negedge clk);
    check("R9", 2'b01, 5'b01111);
    @(negedge clk); sleep_req = 1; irq_pend = 1; standby_ctl = 8'h80;
    @(negedge clk); sleep_req = 0; irq_pend = 0;
    check("R8", 2'b00, 5'b11111);
  endtask

  task automatic t_idle_irq();
    wake(); check("R8", 2'b00, 5'b11111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk); t_reset();
    t_standby();
    t_deep();
    t_sleep();
    t_ignore();
    t_idle_irq();
    strobe(8'h80, 8'h00);
    @(negedge clk); rst_n = 0;
    #1 check("R1", 2'b00, 5'b11111);
    @(negedge clk); rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule